// File: doc/BRIEF.md
# Boot Handshake Mailbox with Status Waiter

This block is a word-addressed mailbox between a host controller and the boot firmware of a remote processor. The host writes an image base address, a command word, a metadata address, a code start address and a code length. The remote side posts progress through two status channels. The first channel belongs to the first-stage loader. The second belongs to the second-stage loader. The remote side cannot see the host's bus. It reads the command and address words on dedicated outputs and writes the two status words through its own port.

A status waiter on the host side saves the host from polling in software. The host starts it with a channel, an expected value and a cycle budget. The waiter then samples the chosen status word once per cycle. It ends on a match, on any negative status, or when the budget runs out. Each phase of a boot (first-stage boot, metadata check, second-stage boot, full authentication) needs its own budget, so the budget is loaded at every start. A typical load proceeds in this order:

1. Clear the length word.
2. Post the metadata address and the metadata-ready command, then wait for the metadata-authenticated code.
3. Write the code start and the load-ready command, then write the length.
4. Wait for authentication complete.

Top module: `boot_mailbox`

## Requirements
- R1: After a synchronous reset every register reads zero, the waiter is idle, and the done, matched, error and timed-out outputs are low.
- R2: The host register map uses word indices, with byte offsets at four times the index: 0 image address, 1 first-stage status, 2 command, 3 second-stage status, 4 metadata address, 5 code start, 6 code length. A host write to index 0, 2, 4, 5 or 6 takes effect at the next clock edge, and `host_rdata` shows the addressed word combinationally.
- R3: Host writes to index 1 or 3 (the status words) and to index 7 (unmapped) change no register. A read of index 7 returns zero.
- R4: A remote write with `rmt_chan` = 0 updates the first-stage status and with `rmt_chan` = 1 the second-stage status, at the next edge. The command, image, metadata, code start and code length words are always driven on the remote outputs.
- R5: `rmt_meta_ready` is high exactly when the command word equals 1, and `rmt_load_ready` exactly when it equals 2.
- R6: When the waiter is idle, `wait_start` captures the channel, the expected value and the budget, and `wait_busy` rises at the next edge. A `wait_start` while busy is ignored.
- R7: A status with bit 31 set (a negative value) ends the wait with `wait_error`, whatever value is expected, even when the expected value is the same negative number.
- R8: With a nonzero expected value, the wait ends with `wait_matched` on the first poll where the status equals it. Examples are 1 for first-stage success, 1 or 2 for second-stage unlocked, 3 for metadata authenticated and 4 for authentication complete.
- R9: With an expected value of zero, the wait ends with `wait_matched` on the first poll that sees any nonzero, non-negative status.
- R10: With budget L, the waiter polls L+1 times. If no poll ends the wait, `wait_timed_out` pulses in the cycle after the last poll, L+2 cycles after the start edge. An immediate hit ends 2 cycles after the start edge.
- R11: `wait_done` is a one-cycle pulse that comes with exactly one of matched, error or timed-out. `wait_status` holds the status seen by the final poll until the next wait ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Host write strobe |
| host_addr | input | AW (3) | Host word index |
| host_wdata | input | DW (32) | Host write data |
| host_rdata | output | DW | Word at host_addr |
| rmt_wr | input | 1 | Remote status write strobe |
| rmt_chan | input | 1 | 0 first-stage, 1 second-stage status |
| rmt_wdata | input | DW | Remote status value |
| rmt_image_addr | output | DW | Image base address word |
| rmt_cmd | output | DW | Command word |
| rmt_meta_addr | output | DW | Metadata address word |
| rmt_code_start | output | DW | Code start word |
| rmt_code_len | output | DW | Code length word |
| rmt_meta_ready | output | 1 | Command equals metadata-ready (1) |
| rmt_load_ready | output | 1 | Command equals load-ready (2) |
| wait_start | input | 1 | Start a wait |
| wait_chan | input | 1 | Status channel to watch |
| wait_expect | input | DW | Expected status, 0 for any nonzero |
| wait_limit | input | CW (16) | Poll budget L (L+1 polls) |
| wait_busy | output | 1 | Wait in progress |
| wait_done | output | 1 | Wait ended (pulse) |
| wait_matched | output | 1 | Ended on match (pulse) |
| wait_error | output | 1 | Ended on negative status (pulse) |
| wait_timed_out | output | 1 | Ended on budget exhaustion (pulse) |
| wait_status | output | DW | Status seen by the final poll |

## Verification
The bench targets the edges of the waiter's decision.

- A negative status while a matching negative value is expected must still report an error. A design that let a match win would report success on a failure code.
- An expected value of zero must accept any nonzero status. A design that compared literally would hang until the timeout.
- A budget of zero must give exactly one poll. Budgets of five and twenty are timed to the cycle, so an off-by-one counter shows up as a latency of one cycle too many or too few.
- A second start during a busy wait whose new channel would match at once must have no effect. A design that re-armed would end early with a match.
- Host writes aimed at the status words must be dropped. A design that accepted them would let the host forge firmware progress.

// File: rtl/boot_mbox_pkg.sv
package boot_mbox_pkg;

    localparam int NUM_REGS = 7;
    localparam int IDX_W    = 3;

    typedef enum logic [IDX_W-1:0] {
        IDX_IMAGE  = 3'd0,
        IDX_STAGE1 = 3'd1,
        IDX_CMD    = 3'd2,
        IDX_STAGE2 = 3'd3,
        IDX_META   = 3'd4,
        IDX_CSTART = 3'd5,
        IDX_CLEN   = 3'd6
    } reg_idx_e;

    typedef enum logic {
        CHAN_STAGE1 = 1'b0,
        CHAN_STAGE2 = 1'b1
    } chan_e;

    typedef enum logic {
        WAIT_IDLE = 1'b0,
        WAIT_BUSY = 1'b1
    } wait_state_e;

    typedef struct packed {
        logic matched;
        logic error;
        logic timed_out;
    } outcome_t;

    localparam int CMD_META_READY = 1;
    localparam int CMD_LOAD_READY = 2;

    localparam int ST1_OK           = 1;
    localparam int ST2_UNLOCKED     = 1;
    localparam int ST2_UNLOCKED_CLR = 2;
    localparam int ST2_META_OK      = 3;
    localparam int ST2_AUTH_DONE    = 4;

    function automatic logic [IDX_W-1:0] chan_index(chan_e c);
        return (c == CHAN_STAGE2) ? IDX_STAGE2 : IDX_STAGE1;
    endfunction

    function automatic logic is_status_index(int i);
        return (i == int'(IDX_STAGE1)) || (i == int'(IDX_STAGE2));
    endfunction

endpackage

// File: rtl/bmx_regfile.sv
module bmx_regfile
    import boot_mbox_pkg::*;
#(
    parameter int DW = 32,
    parameter int AW = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          host_wr,
    input  logic [AW-1:0] host_addr,
    input  logic [DW-1:0] host_wdata,
    output logic [DW-1:0] host_rdata,
    input  logic          rmt_wr,
    input  chan_e         rmt_chan,
    input  logic [DW-1:0] rmt_wdata,
    output logic [DW-1:0] regs_q [NUM_REGS]
);

    localparam int SPAN = 1 << AW;

    logic [IDX_W-1:0] rmt_idx;
    assign rmt_idx = chan_index(rmt_chan);

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        localparam logic [AW-1:0]    HOST_SEL = AW'(i);
        localparam logic [IDX_W-1:0] RMT_SEL  = IDX_W'(i);
        if (is_status_index(i)) begin : g_status
            always_ff @(posedge clk) begin
                if (rst) begin
                    regs_q[i] <= '0;
                end else if (rmt_wr && rmt_idx == RMT_SEL) begin
                    regs_q[i] <= rmt_wdata;
                end
            end
        end else begin : g_host
            always_ff @(posedge clk) begin
                if (rst) begin
                    regs_q[i] <= '0;
                end else if (host_wr && host_addr == HOST_SEL) begin
                    regs_q[i] <= host_wdata;
                end
            end
        end
    end

    always_comb begin
        host_rdata = '0;
        for (int k = 0; k < NUM_REGS && k < SPAN; k++) begin
            if (host_addr == AW'(k)) begin
                host_rdata = regs_q[k];
            end
        end
    end

    a_r3_host_cannot_touch_stage1: assert property (@(posedge clk) disable iff (rst)
        (host_wr && host_addr == AW'(IDX_STAGE1) && !rmt_wr) |=> $stable(regs_q[IDX_STAGE1]));

    a_r3_host_cannot_touch_stage2: assert property (@(posedge clk) disable iff (rst)
        (host_wr && host_addr == AW'(IDX_STAGE2) && !rmt_wr) |=> $stable(regs_q[IDX_STAGE2]));

    a_r4_remote_stage2_lands: assert property (@(posedge clk) disable iff (rst)
        (rmt_wr && rmt_chan == CHAN_STAGE2) |=> regs_q[IDX_STAGE2] == $past(rmt_wdata));

endmodule

// File: rtl/bmx_waiter.sv
module bmx_waiter
    import boot_mbox_pkg::*;
#(
    parameter int DW = 32,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  chan_e         chan_in,
    input  logic [DW-1:0] expect_in,
    input  logic [CW-1:0] limit_in,
    input  logic [DW-1:0] stage1,
    input  logic [DW-1:0] stage2,
    output logic          busy,
    output logic          done,
    output outcome_t      outcome,
    output logic [DW-1:0] status
);

    localparam int SIGN_BIT = DW - 1;

    wait_state_e   state_q;
    chan_e         chan_q;
    logic [DW-1:0] expect_q;
    logic [CW-1:0] budget_q;

    logic [DW-1:0] seen;
    logic          hit_error;
    logic          hit_match;
    logic          exhausted;

    always_comb begin
        seen      = (chan_q == CHAN_STAGE2) ? stage2 : stage1;
        hit_error = seen[SIGN_BIT];
        hit_match = (expect_q == '0) ? (seen != '0) : (seen == expect_q);
        exhausted = (budget_q == '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= WAIT_IDLE;
            chan_q   <= CHAN_STAGE1;
            expect_q <= '0;
            budget_q <= '0;
            done     <= 1'b0;
            outcome  <= '0;
            status   <= '0;
        end else begin
            done    <= 1'b0;
            outcome <= '0;
            case (state_q)
                WAIT_IDLE: begin
                    if (start) begin
                        state_q  <= WAIT_BUSY;
                        chan_q   <= chan_in;
                        expect_q <= expect_in;
                        budget_q <= limit_in;
                    end
                end
                WAIT_BUSY: begin
                    if (hit_error || hit_match || exhausted) begin
                        state_q           <= WAIT_IDLE;
                        done              <= 1'b1;
                        status            <= seen;
                        outcome.error     <= hit_error;
                        outcome.matched   <= !hit_error && hit_match;
                        outcome.timed_out <= !hit_error && !hit_match;
                    end else begin
                        budget_q <= budget_q - 1'b1;
                    end
                end
                default: state_q <= WAIT_IDLE;
            endcase
        end
    end

    assign busy = (state_q == WAIT_BUSY);

    a_r11_single_outcome: assert property (@(posedge clk) disable iff (rst)
        done |-> $countones({outcome.matched, outcome.error, outcome.timed_out}) == 1);

    a_r11_done_is_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r11_quiet_without_done: assert property (@(posedge clk) disable iff (rst)
        !done |-> outcome == '0);

    a_r6_start_arms: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy);

    a_r7_error_is_negative: assert property (@(posedge clk) disable iff (rst)
        (done && outcome.error) |-> status[SIGN_BIT]);

    a_r8_match_nonnegative: assert property (@(posedge clk) disable iff (rst)
        (done && outcome.matched) |-> !status[SIGN_BIT] && status != '0);

endmodule

// File: rtl/bmx_remote_view.sv
module bmx_remote_view
    import boot_mbox_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic [DW-1:0] regs_q [NUM_REGS],
    output logic [DW-1:0] image_addr,
    output logic [DW-1:0] cmd,
    output logic [DW-1:0] meta_addr,
    output logic [DW-1:0] code_start,
    output logic [DW-1:0] code_len,
    output logic          meta_ready,
    output logic          load_ready
);

    assign image_addr = regs_q[IDX_IMAGE];
    assign cmd        = regs_q[IDX_CMD];
    assign meta_addr  = regs_q[IDX_META];
    assign code_start = regs_q[IDX_CSTART];
    assign code_len   = regs_q[IDX_CLEN];
    assign meta_ready = (regs_q[IDX_CMD] == DW'(CMD_META_READY));
    assign load_ready = (regs_q[IDX_CMD] == DW'(CMD_LOAD_READY));

    always_comb begin
        assert (!(meta_ready && load_ready)) else $error("a_r5_flags_exclusive");
    end

endmodule

// File: rtl/boot_mailbox.sv
module boot_mailbox
    import boot_mbox_pkg::*;
#(
    parameter int DW = 32,
    parameter int AW = 3,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          host_wr,
    input  logic [AW-1:0] host_addr,
    input  logic [DW-1:0] host_wdata,
    output logic [DW-1:0] host_rdata,
    input  logic          rmt_wr,
    input  logic          rmt_chan,
    input  logic [DW-1:0] rmt_wdata,
    output logic [DW-1:0] rmt_image_addr,
    output logic [DW-1:0] rmt_cmd,
    output logic [DW-1:0] rmt_meta_addr,
    output logic [DW-1:0] rmt_code_start,
    output logic [DW-1:0] rmt_code_len,
    output logic          rmt_meta_ready,
    output logic          rmt_load_ready,
    input  logic          wait_start,
    input  logic          wait_chan,
    input  logic [DW-1:0] wait_expect,
    input  logic [CW-1:0] wait_limit,
    output logic          wait_busy,
    output logic          wait_done,
    output logic          wait_matched,
    output logic          wait_error,
    output logic          wait_timed_out,
    output logic [DW-1:0] wait_status
);

    logic [DW-1:0] regs_q [NUM_REGS];
    outcome_t      outcome;

    bmx_regfile #(.DW(DW), .AW(AW)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .host_wr    (host_wr),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata),
        .rmt_wr     (rmt_wr),
        .rmt_chan   (chan_e'(rmt_chan)),
        .rmt_wdata  (rmt_wdata),
        .regs_q     (regs_q)
    );

    bmx_waiter #(.DW(DW), .CW(CW)) u_wait (
        .clk       (clk),
        .rst       (rst),
        .start     (wait_start),
        .chan_in   (chan_e'(wait_chan)),
        .expect_in (wait_expect),
        .limit_in  (wait_limit),
        .stage1    (regs_q[IDX_STAGE1]),
        .stage2    (regs_q[IDX_STAGE2]),
        .busy      (wait_busy),
        .done      (wait_done),
        .outcome   (outcome),
        .status    (wait_status)
    );

    bmx_remote_view #(.DW(DW)) u_view (
        .regs_q     (regs_q),
        .image_addr (rmt_image_addr),
        .cmd        (rmt_cmd),
        .meta_addr  (rmt_meta_addr),
        .code_start (rmt_code_start),
        .code_len   (rmt_code_len),
        .meta_ready (rmt_meta_ready),
        .load_ready (rmt_load_ready)
    );

    assign wait_matched   = outcome.matched;
    assign wait_error     = outcome.error;
    assign wait_timed_out = outcome.timed_out;

endmodule

// File: tb/boot_mailbox_tb.sv
module boot_mailbox_tb;

    localparam int DW = 32;
    localparam int AW = 3;
    localparam int CW = 16;
    localparam int WATCHDOG = 100000;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          host_wr = 1'b0;
    logic [AW-1:0] host_addr = '0;
    logic [DW-1:0] host_wdata = '0;
    logic [DW-1:0] host_rdata;
    logic          rmt_wr = 1'b0;
    logic          rmt_chan = 1'b0;
    logic [DW-1:0] rmt_wdata = '0;
    logic [DW-1:0] rmt_image_addr, rmt_cmd, rmt_meta_addr, rmt_code_start, rmt_code_len;
    logic          rmt_meta_ready, rmt_load_ready;
    logic          wait_start = 1'b0;
    logic          wait_chan = 1'b0;
    logic [DW-1:0] wait_expect = '0;
    logic [CW-1:0] wait_limit = '0;
    logic          wait_busy, wait_done, wait_matched, wait_error, wait_timed_out;
    logic [DW-1:0] wait_status;

    always #10 clk = ~clk;

    boot_mailbox #(.DW(DW), .AW(AW), .CW(CW)) u_dut (.*);

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    // ---------------- behavioural reference model ----------------
    logic [DW-1:0] m_r [8];
    bit            m_busy;
    bit            m_chan;
    logic [DW-1:0] m_exp;
    int            m_cnt;
    bit            m_done, m_match, m_err, m_to;
    logic [DW-1:0] m_stat;
    logic [DW-1:0] m_cur;

    always @(posedge clk) begin
        if (rst) begin
            foreach (m_r[k]) m_r[k] = '0;
            m_busy = 0; m_chan = 0; m_exp = '0; m_cnt = 0;
            m_done = 0; m_match = 0; m_err = 0; m_to = 0; m_stat = '0;
        end else begin
            m_done = 0; m_match = 0; m_err = 0; m_to = 0;
            if (m_busy) begin
                m_cur = m_chan ? m_r[3] : m_r[1];
                if (m_cur[DW-1]) begin
                    m_done = 1; m_err = 1; m_stat = m_cur; m_busy = 0;
                end else if ((m_exp == 0) ? (m_cur != 0) : (m_cur == m_exp)) begin
                    m_done = 1; m_match = 1; m_stat = m_cur; m_busy = 0;
                end else if (m_cnt == 0) begin
                    m_done = 1; m_to = 1; m_stat = m_cur; m_busy = 0;
                end else begin
                    m_cnt = m_cnt - 1;
                end
            end else if (wait_start) begin
                m_busy = 1; m_chan = wait_chan; m_exp = wait_expect; m_cnt = int'(wait_limit);
            end
            if (host_wr && (host_addr == 0 || host_addr == 2 || host_addr == 4 ||
                            host_addr == 5 || host_addr == 6))
                m_r[host_addr] = host_wdata;
            if (rmt_wr) m_r[rmt_chan ? 3 : 1] = rmt_wdata;
        end
    end

    // ---------------- per-cycle comparison and done monitor ----------------
    bit            got_done = 0;
    int            got_cyc  = 0;
    bit            got_m, got_e, got_t;
    logic [DW-1:0] got_s;

    always begin
        @(posedge clk);
        #5;
        cyc++;
        chk(host_rdata == m_r[host_addr], "R2 host_rdata", host_rdata, m_r[host_addr]);
        chk(wait_busy == m_busy, "R6 wait_busy", DW'(wait_busy), DW'(m_busy));
        chk(wait_done == m_done, "R11 wait_done", DW'(wait_done), DW'(m_done));
        chk(wait_matched == m_match, "R8 wait_matched", DW'(wait_matched), DW'(m_match));
        chk(wait_error == m_err, "R7 wait_error", DW'(wait_error), DW'(m_err));
        chk(wait_timed_out == m_to, "R10 wait_timed_out", DW'(wait_timed_out), DW'(m_to));
        chk(wait_status == m_stat, "R11 wait_status", wait_status, m_stat);
        chk(rmt_cmd == m_r[2] && rmt_code_len == m_r[6], "R4 remote view", rmt_cmd, m_r[2]);
        chk(rmt_meta_ready == (m_r[2] == 1), "R5 meta_ready", DW'(rmt_meta_ready), DW'(m_r[2] == 1));
        chk(rmt_load_ready == (m_r[2] == 2), "R5 load_ready", DW'(rmt_load_ready), DW'(m_r[2] == 2));
        if (wait_done) begin
            got_done = 1; got_cyc = cyc;
            got_m = wait_matched; got_e = wait_error; got_t = wait_timed_out; got_s = wait_status;
        end
        if (cyc > WATCHDOG) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog expired actual=%0d expected<=%0d", cyc, WATCHDOG);
            finish_run();
        end
    end

    // ---------------- stimulus tasks ----------------
    task automatic hwrite(input int a, input logic [DW-1:0] d);
        @(negedge clk); host_wr = 1; host_addr = AW'(a); host_wdata = d;
        @(negedge clk); host_wr = 0;
    endtask

    task automatic rwrite(input bit ch, input logic [DW-1:0] d);
        @(negedge clk); rmt_wr = 1; rmt_chan = ch; rmt_wdata = d;
        @(negedge clk); rmt_wr = 0;
    endtask

    task automatic hread(input int a, input logic [DW-1:0] exp, input string tag);
        @(negedge clk); host_addr = AW'(a); #1;
        chk(host_rdata == exp, tag, host_rdata, exp);
    endtask

    int t0;
    task automatic start_wait(input bit ch, input logic [DW-1:0] e, input int lim);
        @(negedge clk);
        got_done = 0; t0 = cyc;
        wait_start = 1; wait_chan = ch; wait_expect = e; wait_limit = CW'(lim);
        @(negedge clk); wait_start = 0;
    endtask

    task automatic expect_end(input string tag, input bit m, input bit e, input bit t,
                              input logic [DW-1:0] st, input int lat);
        for (int k = 0; k < 400 && !got_done; k++) @(negedge clk);
        chk(got_done, {tag, " ended"}, DW'(got_done), 1);
        chk({got_m, got_e, got_t} == {m, e, t}, {tag, " outcome"}, DW'({got_m, got_e, got_t}), DW'({m, e, t}));
        chk(got_s == st, {tag, " status"}, got_s, st);
        if (lat > 0) chk(got_cyc - t0 == lat, {tag, " latency"}, DW'(got_cyc - t0), DW'(lat));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        // R1: reset state
        for (int a = 0; a < 8; a++) hread(a, '0, "R1 reset value");
        chk(!wait_busy && !wait_done, "R1 waiter idle", DW'(wait_busy), 0);

        // R2: host map
        hwrite(0, 32'h8000_1000);
        hwrite(4, 32'h8000_2000);
        hwrite(6, 32'h0);
        hread(0, 32'h8000_1000, "R2 image word");
        hread(4, 32'h8000_2000, "R2 meta word");
        chk(rmt_image_addr == 32'h8000_1000 && rmt_meta_addr == 32'h8000_2000,
            "R4 remote addresses", rmt_image_addr, 32'h8000_1000);

        // R3: host writes to status and unmapped words dropped
        hwrite(1, 32'h1234);
        hwrite(3, 32'h5678);
        hwrite(7, 32'h9abc);
        hread(1, '0, "R3 stage1 untouched");
        hread(3, '0, "R3 stage2 untouched");
        hread(7, '0, "R3 unmapped reads zero");

        // R5: command decode
        hwrite(2, 1);
        @(negedge clk);
        chk(rmt_meta_ready && !rmt_load_ready, "R5 meta-ready command", rmt_cmd, 1);

        // R4 + R8: first-stage success
        rwrite(0, 1);
        hread(1, 1, "R4 stage1 via remote");
        start_wait(0, 1, 50);
        expect_end("R8 stage1 ok", 1, 0, 0, 1, 2);

        // R9: expected zero accepts first nonzero
        start_wait(1, 0, 100);
        repeat (4) @(negedge clk);
        rwrite(1, 1);
        expect_end("R9 any nonzero", 1, 0, 0, 1, 0);

        // R7: error mid-wait
        start_wait(1, 3, 100);
        rwrite(1, 2);
        rwrite(1, 32'hFFFF_FFEA);
        expect_end("R7 negative ends wait", 0, 1, 0, 32'hFFFF_FFEA, 0);

        // R8: mismatch then match (metadata authenticated then load)
        rwrite(1, 3);
        start_wait(1, 3, 10);
        expect_end("R8 meta authenticated", 1, 0, 0, 3, 2);
        hwrite(6, 0);
        hwrite(5, 32'h8400_0000);
        hwrite(2, 2);
        hwrite(6, 32'h0002_0000);
        @(negedge clk);
        chk(rmt_load_ready && rmt_code_start == 32'h8400_0000 && rmt_code_len == 32'h0002_0000,
            "R5 load-ready sequence", rmt_code_len, 32'h0002_0000);
        start_wait(1, 4, 100);
        repeat (3) @(negedge clk);
        rwrite(1, 4);
        expect_end("R8 auth complete", 1, 0, 0, 4, 0);

        // R10: timeouts
        rwrite(1, 3);
        start_wait(1, 4, 5);
        expect_end("R10 budget five", 0, 0, 1, 3, 7);
        start_wait(1, 4, 0);
        expect_end("R10 budget zero", 0, 0, 1, 3, 2);

        // R6: start while busy ignored (new request would match at once)
        start_wait(1, 4, 20);
        @(negedge clk); wait_start = 1; wait_chan = 0; wait_expect = 1; wait_limit = 0;
        @(negedge clk); wait_start = 0;
        expect_end("R6 restart ignored", 0, 0, 1, 3, 22);

        // R7: negative wins even when expected equals it, and with expected zero
        rwrite(0, 32'hFFFF_FFFF);
        start_wait(0, 32'hFFFF_FFFF, 10);
        expect_end("R7 equal negative", 0, 1, 0, 32'hFFFF_FFFF, 2);
        start_wait(0, 0, 10);
        expect_end("R7 expected zero", 0, 1, 0, 32'hFFFF_FFFF, 2);

        // R1: reset mid-operation clears everything
        start_wait(1, 4, 100);
        @(negedge clk); rst = 1;
        @(negedge clk); rst = 0;
        hread(3, '0, "R1 stage2 cleared");
        hread(2, '0, "R1 command cleared");
        chk(!wait_busy, "R1 waiter cleared", DW'(wait_busy), 0);

        repeat (5) @(negedge clk);
        finish_run();
    end

endmodule